// File: doc/BRIEF.md
# Comparator Two-Phase Trigger Sequencer

This block is a low-power periodic timer that drives a shared two-phase trigger to a set of comparator channels. The timer counts up to a programmed compare value. Each match sets a compare flag and starts a sequence. The first phase powers up the comparator and reference DAC of every participating channel. After a delay, the second phase makes each participating channel latch its comparator output into a result register. The delay depends on whether the prescaler is in use.

The block runs on a system clock. An internal timer tick occurs on every second system cycle while the timer is enabled. The timer advances either on each tick (prescaler bypassed) or on each prescaler output. The prescaler output fires once every 2^(p+1) ticks, where p is `psc_sel`. There is no separate enable for the trigger output. Each channel takes part in a sequence only if its enable bit was set at the match that started it, so one shared trigger can fire any subset of channels at the same time.

Top module: `cmp_trig_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `match_flag`, `pwr_en`, `cap_stb` and `result_vld` are all 0.
- R2: On a timer match, `match_flag` goes high in the same cycle that `pwr_en` rises. A one-cycle `flag_clr` pulse clears the flag. When a match and `flag_clr` occur in the same cycle, the match wins and the flag stays high.
- R3: The timer counts from 0 up to `cmp_val` and then wraps. With `psc_bypass`=1, consecutive matches are 2*(N+1) system cycles apart, where N is `cmp_val`. With `psc_bypass`=0, they are 2^(p+2)*(N+1) cycles apart.
- R4: `pwr_en[i]` and `cap_stb[i]` are active only for channels whose `chan_en[i]` was 1 at the starting match. Several channels can be active in the same sequence.
- R5: With `psc_bypass`=1, `cap_stb` is asserted exactly 1 system cycle after `pwr_en` rises (half a timer tick period).
- R6: With `psc_bypass`=0, `cap_stb` is asserted exactly 2^(p+1) system cycles after `pwr_en` rises (half a prescaler output period).
- R7: `cap_stb` lasts one cycle. `pwr_en` stays high from the match through the capture cycle and drops in the next cycle.
- R8: In the cycle after capture, `result[i]` holds the value `cmp_out[i]` had in the capture cycle, and `result_vld[i]` is 1, for every participating channel.
- R9: The `result` and `result_vld` bits of non-participating channels do not change on a capture.
- R10: A match that occurs while a sequence is pending sets the flag again. It does not restart or shorten the pending sequence and does not start a new one.
- R11: The trigger is active whenever `tmr_en` is 1. When `tmr_en` is 0, the timer and prescaler are held at zero and no new match occurs. A sequence already started still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_en | input | 1 | Timer enable; the trigger is live whenever this is set |
| cmp_val | input | CW | Timer compare value |
| psc_bypass | input | 1 | 1 = timer advances on every tick |
| psc_sel | input | PW | Prescaler exponent p; divide by 2^(p+1) |
| flag_clr | input | 1 | Write-one-to-clear pulse for the compare flag |
| chan_en | input | NCH | Per-channel trigger-mode enable |
| cmp_out | input | NCH | Raw digital comparator outputs |
| match_flag | output | 1 | Timer compare flag |
| pwr_en | output | NCH | First-phase strobe: comparator and DAC power-up |
| cap_stb | output | NCH | Second-phase one-cycle capture strobe |
| result | output | NCH | Captured comparator results |
| result_vld | output | NCH | Set once a channel has captured |

## Verification
The assertions check the following on every cycle:
- flag/strobe coincidence and match-over-clear priority (R2);
- the one-cycle capture and the power strobe dropping after it (R7);
- the bypassed one-cycle gap (R5);
- valid setting and result holding for idle channels (R8, R9);
- a pending sequence staying undisturbed by new matches (R10).

The bench scenarios cover the rest:
- the absolute match periods and the prescaled gaps over several prescaler settings (R3, R6);
- the captured values against channel subsets (R4, R8, R9);
- a sequence started under the prescaler while matches keep arriving in bypass mode (R10).

// File: rtl/cmp_trig_seq.sv
module cmp_trig_seq #(
  parameter int NCH = 2,
  parameter int CW  = 16,
  parameter int PW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tmr_en,
  input  logic [CW-1:0]  cmp_val,
  input  logic           psc_bypass,
  input  logic [PW-1:0]  psc_sel,
  input  logic           flag_clr,
  input  logic [NCH-1:0] chan_en,
  input  logic [NCH-1:0] cmp_out,
  output logic           match_flag,
  output logic [NCH-1:0] pwr_en,
  output logic [NCH-1:0] cap_stb,
  output logic [NCH-1:0] result,
  output logic [NCH-1:0] result_vld
);
  localparam int PSW = 1 << PW;
  localparam int DW  = PSW + 1;

  logic           phase, tick, psc_out, adv, match, start, cap_evt, busy;
  logic [PSW-1:0] psc_cnt, psc_mask;
  logic [CW-1:0]  tcnt;
  logic [DW-1:0]  dly, gap;
  logic [NCH-1:0] part;

  assign tick     = phase & tmr_en;
  assign psc_mask = ~(({PSW{1'b1}} << psc_sel) << 1);
  assign psc_out  = tick & (&(psc_cnt | ~psc_mask));
  assign adv      = psc_bypass ? tick : psc_out;
  assign match    = adv & (tcnt == cmp_val);
  assign start    = match & ~busy;
  assign cap_evt  = busy & (dly == '0);
  assign gap      = psc_bypass ? DW'(1) : (DW'(2) << psc_sel);

  assign pwr_en  = busy ? part : '0;
  assign cap_stb = cap_evt ? part : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) phase <= 1'b0;
    else        phase <= tmr_en & ~phase;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       psc_cnt <= '0;
    else if (!tmr_en) psc_cnt <= '0;
    else if (tick)    psc_cnt <= psc_out ? '0 : psc_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       tcnt <= '0;
    else if (!tmr_en) tcnt <= '0;
    else if (adv)     tcnt <= match ? '0 : tcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        match_flag <= 1'b0;
    else if (match)    match_flag <= 1'b1;
    else if (flag_clr) match_flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      dly  <= '0;
      part <= '0;
    end else if (start) begin
      busy <= 1'b1;
      dly  <= gap;
      part <= chan_en;
    end else if (cap_evt) begin
      busy <= 1'b0;
    end else if (busy) begin
      dly  <= dly - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      result     <= '0;
      result_vld <= '0;
    end else if (cap_evt) begin
      result     <= (result & ~part) | (cmp_out & part);
      result_vld <= result_vld | part;
    end

  AST_FLAG_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> match_flag); // R2
  AST_MATCH_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (match && flag_clr) |=> match_flag); // R2
  AST_CAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> !cap_evt); // R7
  AST_PWR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (pwr_en == '0)); // R7
  AST_CAP_UNDER_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap_stb & ~pwr_en) == '0)); // R7
  AST_BYPASS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (start && psc_bypass) |=> ##1 cap_evt); // R5
  AST_VLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> ((result_vld & $past(part)) == $past(part))); // R8
  AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (((result ^ $past(result)) & ~$past(part)) == '0)); // R9
  AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cap_evt && match) |=> (busy && dly == $past(dly) - 1'b1)); // R10
endmodule

// File: tb/tb_cmp_trig_seq.sv
module tb_cmp_trig_seq;
  logic       clk = 0, rst_n = 0, tmr_en = 0, psc_bypass = 1, flag_clr = 0;
  logic [15:0] cmp_val = 0;
  logic [3:0] psc_sel = 0;
  logic [1:0] chan_en = 0, cmp_out = 0;
  logic       match_flag;
  logic [1:0] pwr_en, cap_stb, result, result_vld;

  cmp_trig_seq dut (.clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .cmp_val(cmp_val),
    .psc_bypass(psc_bypass), .psc_sel(psc_sel), .flag_clr(flag_clr), .chan_en(chan_en),
    .cmp_out(cmp_out), .match_flag(match_flag), .pwr_en(pwr_en), .cap_stb(cap_stb),
    .result(result), .result_vld(result_vld));

  always #4 clk = ~clk;

  typedef struct { int gap; int period; logic [1:0] part; logic [1:0] res; logic [1:0] vld; } exp_t;
  exp_t q[$];
  exp_t cur;
  int nchk = 0, nbad = 0, cyc = 0, rises = 0, t1 = 0, t0 = 0;
  logic prev_pwr = 0, prev_cap = 0, pend = 0;
  logic [1:0] e_res = 0, e_vld = 0;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (pend) begin
      chk("R8 result", result, cur.res);
      chk("R9 result_vld", result_vld, cur.vld);
      pend = 0;
    end
    if (rst_n) begin
      if (|pwr_en && !prev_pwr) begin
        t0 = t1; t1 = cyc; rises++;
        chk("R2 flag at start", match_flag, 1);
      end
      if (|cap_stb) begin
        chk("R7 single-cycle cap", prev_cap, 0);
        if (q.size() == 0) chk("R10 unexpected capture", 1, 0);
        else begin
          cur = q.pop_front();
          chk("R5/R6 gap", cyc - t1, cur.gap);
          chk("R4 cap mask", cap_stb, cur.part);
          chk("R4 pwr mask", pwr_en, cur.part);
          if (cur.period != 0) chk("R3 period", t1 - t0, cur.period);
          pend = 1;
        end
      end
      if (prev_cap) chk("R7 pwr drops", pwr_en, 0);
    end
    prev_pwr = |pwr_en;
    prev_cap = |cap_stb;
  end

  task automatic run(input logic byp, input int p, input int n, input logic [1:0] en,
                     input logic [1:0] cv, input int cnt);
    int target;
    int g;
    exp_t e;
    g = byp ? 1 : (2 << p);
    for (int k = 0; k < cnt; k++) begin
      e_res = (e_res & ~en) | (cv & en);
      e_vld = e_vld | en;
      e.gap = g;
      e.period = (k == 0) ? 0 : (byp ? 2*(n+1) : (4 << p)*(n+1));
      e.part = en; e.res = e_res; e.vld = e_vld;
      q.push_back(e);
    end
    @(negedge clk);
    psc_bypass = byp; psc_sel = p[3:0]; cmp_val = n[15:0]; chan_en = en; cmp_out = cv;
    tmr_en = 1;
    target = rises + cnt;
    while (rises < target) @(negedge clk);
    tmr_en = 0;
    while (q.size() != 0 || pend) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R11 no match while disabled", rises, target);
    flag_clr = 1;
    @(negedge clk);
    flag_clr = 0;
    @(negedge clk);
    chk("R2 flag cleared", match_flag, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    exp_t e;
    int target;
    repeat (3) @(negedge clk);
    chk("R1 flag", match_flag, 0);
    chk("R1 pwr", pwr_en, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cap", cap_stb, 0);
    chk("R1 vld", result_vld, 0);

    run(1'b1, 0, 2, 2'b10, 2'b11, 3);
    run(1'b0, 1, 1, 2'b11, 2'b10, 2);
    run(1'b0, 0, 2, 2'b01, 2'b01, 2);
    run(1'b0, 3, 0, 2'b11, 2'b00, 2);

    e_res = 2'b01; e_vld = 2'b11;
    e.gap = 8; e.period = 0; e.part = 2'b11; e.res = 2'b01; e.vld = 2'b11;
    q.push_back(e);
    @(negedge clk);
    psc_bypass = 0; psc_sel = 2; cmp_val = 0; chan_en = 2'b11; cmp_out = 2'b01;
    tmr_en = 1;
    target = rises + 1;
    while (rises < target) @(negedge clk);
    psc_bypass = 1; flag_clr = 1;
    @(negedge clk);
    flag_clr = 0;
    while (!(|cap_stb)) @(negedge clk);
    chk("R10 flag set again while pending", match_flag, 1);
    tmr_en = 0;
    while (q.size() != 0 || pend) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R10 no extra sequence", rises, target);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule